// File: doc/BRIEF.md
# SCL Stretch Timeout Watchdog

This block guards an I2C master against a target that holds the clock line low indefinitely. While the master has let go of SCL and expects it to rise, the block counts SCL bit-period ticks from the bit-rate divider. If the sampled line is still low when the count reaches a programmable 16-bit limit, the block raises a sticky timeout flag and sends a one-cycle abort request to the transfer sequencer, which ends the transfer in progress as an error.

The limit is expressed in whole SCL bit periods, not core clock cycles. A limit of zero turns detection off entirely. Software clears the flag by writing a status word in which bit 9 is one. Glitch filtering on the bus line is handled elsewhere.

Top module: `stretch_timeout`

## Requirements
- R1: After reset, `stretchTimeout` and `abortReq` are both 0.
- R2: With limit N (1..65535), the master releasing SCL and SCL sampled low, `stretchTimeout` and `abortReq` become 1 at the clock edge that takes in the Nth tick, and not at any earlier tick.
- R3: Clock cycles without `tickEn` high do not advance the count.
- R4: A cycle with `sclLevel` high restarts the count from zero, so a full N further ticks are needed to expire.
- R5: A cycle with `sclRelease` low (master driving SCL low) restarts the count from zero.
- R6: A limit of 0 disables detection: no tick count ever sets the flag or requests an abort.
- R7: Once set, `stretchTimeout` stays 1 when SCL later rises or the master drives it, until software clears it.
- R8: A cycle with `clrWrite` high and `clrData[9]` = 1 clears the flag at the next edge; a write with `clrData[9]` = 0 leaves it unchanged, whatever the other bits hold.
- R9: When an expiry and a clearing write fall in the same cycle, the flag ends set.
- R10: `abortReq` is a single-cycle pulse on every expiry; the count restarts at zero on expiry, so a line held low expires again after another N ticks.
- R11: If the limit is lowered to or below the count already reached, the next qualifying tick expires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle pulse per SCL bit period from the divider |
| sclRelease | input | 1 | Master is releasing SCL (1) or driving it low (0) |
| sclLevel | input | 1 | Synchronised level of the SCL line |
| limitValue | input | 16 | Timeout limit in SCL bit periods; 0 disables |
| clrWrite | input | 1 | Status write strobe |
| clrData | input | 16 | Status write data; bit 9 set clears the flag |
| stretchTimeout | output | 1 | Sticky timeout flag |
| abortReq | output | 1 | One-cycle abort request to the sequencer |

## Verification
The expiry that sets the flag and the software write that clears it can land in the same core cycle. The bench provokes this by raising the final qualifying tick and a clearing write on one edge after a previous timeout has left the flag set, then judges that the flag reads 1 and an abort pulse is seen. It also sweeps every limit from 1 to 6, checking flag and abort after each tick against the tick number.

// File: rtl/stretch_pkg.sv
package stretch_pkg;
  // Strobes from the control to the counting datapath.
  typedef struct packed {
    logic cntClear;  // restart the count from zero
    logic cntInc;    // advance the count by one
    logic expire;    // limit reached on this tick
    logic flagClr;   // software clear request
  } stretchCtl_t;
endpackage

// File: rtl/stretch_dp.sv
module stretch_dp
  import stretch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stretchCtl_t      ctl,
  input  logic [CNT_W-1:0] limitValue,
  output logic             limitOff,
  output logic             reachNext
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] countQ;
  logic [EXT_W-1:0] countNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= '0;
    else if (ctl.cntClear || ctl.expire) countQ <= '0;
    else if (ctl.cntInc) countQ <= countNext[CNT_W-1:0];
  end

  // Widened so the comparison cannot wrap; >= also covers a limit lowered mid-window.
  assign countNext = {1'b0, countQ} + EXT_W'(1);
  assign reachNext = countNext >= {1'b0, limitValue};
  assign limitOff  = (limitValue == '0);
endmodule

// File: rtl/stretch_ctl.sv
module stretch_ctl
  import stretch_pkg::*;
#(
  parameter int STATUS_W = 16,
  parameter int CLR_BIT  = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                sclRelease,
  input  logic                sclLevel,
  input  logic                limitOff,
  input  logic                reachNext,
  input  logic                clrWrite,
  input  logic [STATUS_W-1:0] clrData,
  output stretchCtl_t         ctl,
  output logic                flagQ,
  output logic                abortQ
);
  logic lowHeld;
  logic advance;
  logic unusedBits;

  assign unusedBits = ^clrData;
  assign lowHeld    = sclRelease && !sclLevel;
  assign advance    = lowHeld && tickEn && !limitOff;

  always_comb begin
    ctl          = '0;
    ctl.cntClear = !lowHeld || limitOff;
    ctl.expire   = advance && reachNext;
    ctl.cntInc   = advance && !reachNext;
    ctl.flagClr  = clrWrite && clrData[CLR_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= 1'b0;
      abortQ <= 1'b0;
    end else begin
      abortQ <= ctl.expire;
      if (ctl.expire) flagQ <= 1'b1;       // expiry beats a same-cycle clear
      else if (ctl.flagClr) flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/stretch_timeout.sv
module stretch_timeout
  import stretch_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int STATUS_W = 16,
  parameter int CLR_BIT  = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                sclRelease,
  input  logic                sclLevel,
  input  logic [CNT_W-1:0]    limitValue,
  input  logic                clrWrite,
  input  logic [STATUS_W-1:0] clrData,
  output logic                stretchTimeout,
  output logic                abortReq
);
  stretchCtl_t ctl;
  logic limitOff;
  logic reachNext;

  stretch_ctl #(.STATUS_W(STATUS_W), .CLR_BIT(CLR_BIT)) ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sclRelease(sclRelease),
    .sclLevel(sclLevel), .limitOff(limitOff), .reachNext(reachNext),
    .clrWrite(clrWrite), .clrData(clrData), .ctl(ctl),
    .flagQ(stretchTimeout), .abortQ(abortReq)
  );

  stretch_dp #(.CNT_W(CNT_W)) dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .limitValue(limitValue),
    .limitOff(limitOff), .reachNext(reachNext)
  );
endmodule

// File: rtl/stretch_timeout_chk.sv
module stretch_timeout_chk #(
  parameter int CNT_W    = 16,
  parameter int STATUS_W = 16,
  parameter int CLR_BIT  = 9
) (
  input logic                clk,
  input logic                rstN,
  input logic                tickEn,
  input logic                sclRelease,
  input logic                sclLevel,
  input logic [CNT_W-1:0]    limitValue,
  input logic                clrWrite,
  input logic [STATUS_W-1:0] clrData,
  input logic                stretchTimeout,
  input logic                abortReq
);
  assert_abort_sets_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> stretchTimeout);

  assert_rise_has_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stretchTimeout) |-> abortReq);

  assert_no_tick_no_abort_R3: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> !abortReq);

  assert_high_no_abort_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sclLevel || !sclRelease) |=> !abortReq);

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (limitValue == '0) |=> !abortReq);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stretchTimeout && !(clrWrite && clrData[CLR_BIT])) |=> stretchTimeout);

  assert_clear_wins_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && clrData[CLR_BIT] && !tickEn) |=> !stretchTimeout);
endmodule

bind stretch_timeout stretch_timeout_chk #(.CNT_W(CNT_W), .STATUS_W(STATUS_W), .CLR_BIT(CLR_BIT)) chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .sclRelease(sclRelease), .sclLevel(sclLevel),
  .limitValue(limitValue), .clrWrite(clrWrite), .clrData(clrData),
  .stretchTimeout(stretchTimeout), .abortReq(abortReq)
);

// File: tb/stretch_timeout_test.sv
module stretch_timeout_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic sclRelease = 1'b0;
  logic sclLevel = 1'b1;
  logic [15:0] limitValue = 16'd0;
  logic clrWrite = 1'b0;
  logic [15:0] clrData = 16'd0;
  logic stretchTimeout;
  logic abortReq;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  stretch_timeout uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sclRelease(sclRelease),
    .sclLevel(sclLevel), .limitValue(limitValue), .clrWrite(clrWrite),
    .clrData(clrData), .stretchTimeout(stretchTimeout), .abortReq(abortReq)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {flag,abort} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock with a tick; returns at the negedge after the edge that took it.
  task automatic doTick();
    @(negedge clk) tickEn = 1'b1;
    @(negedge clk) tickEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeStatus(input logic [15:0] d);
    @(negedge clk) begin clrWrite = 1'b1; clrData = d; end
    @(negedge clk) begin clrWrite = 1'b0; clrData = 16'd0; end
  endtask

  task automatic restart();
    @(negedge clk) sclRelease = 1'b0;
    @(negedge clk) begin sclRelease = 1'b1; sclLevel = 1'b0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {stretchTimeout, abortReq}, 2'b00);
    rstN = 1'b1;
    idle(2);
    check("R1 after release", {stretchTimeout, abortReq}, 2'b00);

    // R2 sweep over limits 1..6
    for (int lim = 1; lim <= 6; lim++) begin
      limitValue = 16'(lim);
      writeStatus(16'h0200);
      restart();
      for (int k = 1; k <= lim; k++) begin
        doTick();
        check($sformatf("R2 lim=%0d tick=%0d", lim, k), {stretchTimeout, abortReq},
              {k == lim, k == lim});
      end
      idle(1);
      check("R10 abort single pulse", {stretchTimeout, abortReq}, 2'b10);
    end

    // R7 sticky through SCL rising and master driving
    @(negedge clk) sclLevel = 1'b1;
    idle(4);
    check("R7 sticky SCL high", {stretchTimeout, abortReq}, 2'b10);
    @(negedge clk) sclRelease = 1'b0;
    doTick();
    check("R7 sticky master low", {stretchTimeout, abortReq}, 2'b10);

    // R8 write without bit 9 has no effect, with bit 9 clears
    writeStatus(16'hFDFF);
    check("R8 other bits ignored", {stretchTimeout, abortReq}, 2'b10);
    writeStatus(16'h0200);
    check("R8 clear", {stretchTimeout, abortReq}, 2'b00);

    // R3 idle cycles do not count
    limitValue = 16'd3;
    restart();
    doTick(); doTick();
    idle(7);
    check("R3 no tick no count", {stretchTimeout, abortReq}, 2'b00);
    doTick();
    check("R3 third tick expires", {stretchTimeout, abortReq}, 2'b11);

    // R10 re-expiry after another N ticks
    doTick();
    check("R10 restart tick1", {stretchTimeout, abortReq}, 2'b10);
    doTick();
    check("R10 restart tick2", {stretchTimeout, abortReq}, 2'b10);
    doTick();
    check("R10 second expiry", {stretchTimeout, abortReq}, 2'b11);
    writeStatus(16'h0200);

    // R4 SCL high restarts the count
    restart();
    doTick(); doTick();
    @(negedge clk) sclLevel = 1'b1;
    @(negedge clk) sclLevel = 1'b0;
    doTick(); doTick();
    check("R4 restart after high", {stretchTimeout, abortReq}, 2'b00);
    doTick();
    check("R4 full window", {stretchTimeout, abortReq}, 2'b11);
    writeStatus(16'h0200);

    // R5 master driving low restarts the count
    restart();
    doTick(); doTick();
    @(negedge clk) sclRelease = 1'b0;
    @(negedge clk) sclRelease = 1'b1;
    doTick(); doTick();
    check("R5 restart after drive", {stretchTimeout, abortReq}, 2'b00);
    doTick();
    check("R5 full window", {stretchTimeout, abortReq}, 2'b11);

    // R9 expiry and clear in the same cycle (flag already set)
    doTick(); doTick();
    @(negedge clk) begin tickEn = 1'b1; clrWrite = 1'b1; clrData = 16'h0200; end
    @(negedge clk) begin tickEn = 1'b0; clrWrite = 1'b0; clrData = 16'h0; end
    check("R9 set beats clear", {stretchTimeout, abortReq}, 2'b11);
    writeStatus(16'h0200);

    // R6 limit zero disables
    limitValue = 16'd0;
    restart();
    for (int k = 0; k < 40; k++) doTick();
    check("R6 disabled", {stretchTimeout, abortReq}, 2'b00);

    // R11 limit lowered below count
    limitValue = 16'd10;
    restart();
    for (int k = 0; k < 5; k++) doTick();
    check("R11 before lowering", {stretchTimeout, abortReq}, 2'b00);
    limitValue = 16'd3;
    doTick();
    check("R11 lowered limit expires", {stretchTimeout, abortReq}, 2'b11);

    // R2 at the top limit value: no expiry after many ticks
    writeStatus(16'h0200);
    limitValue = 16'hFFFF;
    restart();
    for (int k = 0; k < 100; k++) doTick();
    check("R2 large limit not reached", {stretchTimeout, abortReq}, 2'b00);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule